// File: doc/BRIEF.md
# Windowed I/Q Signal-Strength Accumulator

This block measures received signal strength for one receive channel. It takes signed I and Q samples from the channel filter, with a sample strobe and a slot-start pulse. Samples are numbered from the slot start, and only the samples that fall in a programmable window contribute. For each of those samples the block takes the integer vector magnitude, scales it by a fixed gain of about 0.4117 and by a programmable fractional gain, and adds the result to a running total that saturates instead of wrapping. When the window closes, the total is copied to a 16-bit read-only output and a one-cycle done strobe is raised.

The datapath is sequential. An iterative square root runs for one result bit per cycle, so one accepted sample takes 19 cycles. At the nominal sample spacing of about 20.8 µs, this is far below one sample period. The controller has four states. `ST_IDLE` waits for a strobe. `ST_ROOT` waits for the root. `ST_SCALE` registers the first gain product and then adds to the total. `ST_PUB` copies the total to the output. The transitions are as follows. IDLE goes to ROOT on an in-window strobe (start_root). IDLE goes to PUB on a strobe at the closing index of an empty window (empty_close). ROOT goes to SCALE when the root is ready (root_ready). SCALE goes to PUB if the sample closes the window (close_pub), and otherwise back to IDLE (next_sample). PUB goes back to IDLE (publish_done). A slot-start pulse sends every state to IDLE (slot_abort).

Top module: `rssi_win_acc`

## Requirements
- R1: After reset `rssi_out` is 0 and `win_done` is 0.
- R2: Each accepted sample contributes c = round(round(m·26981/65536)·g/65536). Here m = floor(sqrt(I²+Q²)), g is `cfg_gain`, and each rounding adds half an LSB and then truncates.
- R3: The first strobe accepted after a slot start has index 0, and each later accepted strobe has the next index. Only indices from `cfg_start` through `cfg_start + cfg_len − 2` inclusive contribute. Samples outside that range, including samples after the window closes, change nothing.
- R4: The running total saturates at 32767 and never exceeds it.
- R5: Call the edge that samples the strobe of the closing-index sample edge 0. At edge 19, `rssi_out` takes the total and `win_done` is high for exactly one cycle.
- R6: If `cfg_len` is below 2, the window is empty. The strobe at index `cfg_start` publishes 0, with `win_done` high at edge 1.
- R7: A `slot_start` pulse clears the total and the index and aborts a sample in progress without publishing. A strobe in the same cycle as the pulse is ignored. `rssi_out` keeps its value, and `win_done` is low in the cycle after the pulse.
- R8: A strobe that arrives while a sample is still being processed is ignored and is not counted. Strobes must be at least 19 cycles apart.
- R9: With `cfg_gain` = 0, every contribution is 0, so the published value is 0.
- R10: `rssi_out` changes only in a cycle in which `win_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_i | input | 16 | Signed in-phase sample |
| smp_q | input | 16 | Signed quadrature sample |
| smp_stb | input | 1 | Sample strobe, one cycle per sample |
| slot_start | input | 1 | Slot-start pulse |
| cfg_start | input | 11 | First window index |
| cfg_len | input | 11 | Window length; the last index is start + len − 2 |
| cfg_gain | input | 16 | Unsigned Q0.16 user gain |
| rssi_out | output | 16 | Published signal strength |
| win_done | output | 1 | One-cycle strobe when the window closes |

## Verification
The published value and the done strobe are due at edge 19 after the closing strobe is sampled. For an empty window they are due at edge 1. The bench drives stimulus on falling edges and counts rising edges from the strobe. It checks that nothing has moved at edge 18, that both outputs have moved at edge 19, and that the strobe has dropped one edge later. Between samples the bench waits 22 edges, so every earlier result has settled before the next strobe. During an abort, the done output is sampled on every falling edge across the whole interval in which a publish would otherwise have fallen.

// File: rtl/rssi_pkg.sv
package rssi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROOT  = 2'd1,
        ST_SCALE = 2'd2,
        ST_PUB   = 2'd3
    } acc_state_e;

    localparam int unsigned FIXED_GAIN_Q16 = 26981;
endpackage

// File: rtl/rssi_isqrt_seq.sv
module rssi_isqrt_seq #(
    parameter int RAD_W  = 32,
    parameter int ROOT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RAD_W-1:0]  radicand,
    output logic [ROOT_W-1:0] root,
    output logic              ready
);
    localparam int CNT_W = $clog2(ROOT_W);

    logic [RAD_W-1:0] rem_q, res_q, bit_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic [RAD_W:0]   trial;

    assign trial = {1'b0, res_q} + {1'b0, bit_q};
    assign root  = ROOT_W'(res_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= '0;
            res_q    <= '0;
            bit_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            ready    <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (start) begin
                rem_q    <= radicand;
                res_q    <= '0;
                bit_q    <= RAD_W'(1) << (RAD_W - 2);
                cnt_q    <= '0;
                active_q <= 1'b1;
            end else if (active_q) begin
                if ({1'b0, rem_q} >= trial) begin
                    rem_q <= rem_q - RAD_W'(trial);
                    res_q <= (res_q >> 1) + bit_q;
                end else begin
                    res_q <= res_q >> 1;
                end
                bit_q <= bit_q >> 2;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(ROOT_W - 1)) begin
                    active_q <= 1'b0;
                    ready    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rssi_round_mul.sv
module rssi_round_mul #(
    parameter int A_W = 16,
    parameter int F_W = 16
) (
    input  logic [A_W-1:0] a,
    input  logic [F_W-1:0] frac,
    output logic [A_W-1:0] y
);
    localparam int P_W = A_W + F_W + 1;

    logic [P_W-1:0] prod;

    assign prod = P_W'(a) * P_W'(frac) + (P_W'(1) << (F_W - 1));
    assign y    = A_W'(prod >> F_W);
endmodule

// File: rtl/rssi_win_acc.sv
module rssi_win_acc
    import rssi_pkg::*;
#(
    parameter int SMP_W  = 16,
    parameter int IDX_W  = 11,
    parameter int GAIN_W = 16,
    parameter int OUT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SMP_W-1:0]  smp_i,
    input  logic [SMP_W-1:0]  smp_q,
    input  logic              smp_stb,
    input  logic              slot_start,
    input  logic [IDX_W-1:0]  cfg_start,
    input  logic [IDX_W-1:0]  cfg_len,
    input  logic [GAIN_W-1:0] cfg_gain,
    output logic [OUT_W-1:0]  rssi_out,
    output logic              win_done
);
    localparam int RAD_W   = 2 * SMP_W;
    localparam int ROOT_W  = SMP_W;
    localparam int SQ_W    = RAD_W + 1;
    localparam int CLOSE_W = IDX_W + 1;
    localparam int SUM_W   = OUT_W + 1;
    localparam logic [OUT_W-1:0]  SAT_MAX   = OUT_W'((1 << (OUT_W - 1)) - 1);
    localparam logic [GAIN_W-1:0] FIX_GAIN  = GAIN_W'(FIXED_GAIN_Q16);

    acc_state_e state_q, state_d;

    logic [IDX_W-1:0]   idx_q;
    logic [OUT_W-1:0]   acc_q;
    logic [ROOT_W-1:0]  fix_q;
    logic               close_q;

    // Window decode
    logic               len_ok, in_win, closing;
    logic [CLOSE_W-1:0] close_idx;

    assign len_ok    = cfg_len >= IDX_W'(2);
    assign close_idx = len_ok ? ({1'b0, cfg_start} + {1'b0, cfg_len} - CLOSE_W'(2))
                              : {1'b0, cfg_start};
    assign in_win    = len_ok && (idx_q >= cfg_start) && ({1'b0, idx_q} <= close_idx);
    assign closing   = ({1'b0, idx_q} == close_idx);

    // Magnitude squared
    logic signed [SQ_W-1:0] i_sq, q_sq;
    logic [SQ_W-1:0]        sq_sum;
    logic [RAD_W-1:0]       radicand;

    assign i_sq     = SQ_W'($signed(smp_i)) * SQ_W'($signed(smp_i));
    assign q_sq     = SQ_W'($signed(smp_q)) * SQ_W'($signed(smp_q));
    assign sq_sum   = SQ_W'(i_sq + q_sq);
    assign radicand = RAD_W'(sq_sum);

    logic              take_smp, root_start, root_ready;
    logic [ROOT_W-1:0] root;

    assign take_smp   = (state_q == ST_IDLE) && smp_stb && !slot_start;
    assign root_start = take_smp && in_win;

    rssi_isqrt_seq #(.RAD_W(RAD_W), .ROOT_W(ROOT_W)) u_root (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (root_start),
        .radicand (radicand),
        .root     (root),
        .ready    (root_ready)
    );

    // Gain stages
    logic [ROOT_W-1:0] fix_prod, user_prod;

    rssi_round_mul #(.A_W(ROOT_W), .F_W(GAIN_W)) u_fix_gain (
        .a    (root),
        .frac (FIX_GAIN),
        .y    (fix_prod)
    );

    rssi_round_mul #(.A_W(ROOT_W), .F_W(GAIN_W)) u_user_gain (
        .a    (fix_q),
        .frac (cfg_gain),
        .y    (user_prod)
    );

    logic [SUM_W-1:0] acc_sum;
    logic [OUT_W-1:0] acc_sat;

    assign acc_sum = {1'b0, acc_q} + SUM_W'(user_prod);
    assign acc_sat = (acc_sum > SUM_W'(SAT_MAX)) ? SAT_MAX : OUT_W'(acc_sum);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_smp && in_win)       state_d = ST_ROOT;
                else if (take_smp && closing) state_d = ST_PUB;
            end
            ST_ROOT:  if (root_ready) state_d = ST_SCALE;
            ST_SCALE: state_d = close_q ? ST_PUB : ST_IDLE;
            ST_PUB:   state_d = ST_IDLE;
        endcase
        if (slot_start) state_d = ST_IDLE;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            acc_q   <= '0;
            fix_q   <= '0;
            close_q <= 1'b0;
        end else if (slot_start) begin
            idx_q   <= '0;
            acc_q   <= '0;
            close_q <= 1'b0;
        end else begin
            if (take_smp) begin
                close_q <= closing;
                if (idx_q != '1) idx_q <= idx_q + 1'b1;
            end
            if (state_q == ST_ROOT && root_ready) fix_q <= fix_prod;
            if (state_q == ST_SCALE)              acc_q <= acc_sat;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rssi_out <= '0;
            win_done <= 1'b0;
        end else begin
            win_done <= (state_q == ST_PUB) && !slot_start;
            if (state_q == ST_PUB && !slot_start) rssi_out <= acc_q;
        end
    end
endmodule

// File: rtl/rssi_win_acc_chk.sv
module rssi_win_acc_chk #(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slot_start,
    input logic [OUT_W-1:0] rssi_out,
    input logic             win_done
);
    localparam logic [OUT_W-1:0] SAT_MAX = OUT_W'((1 << (OUT_W - 1)) - 1);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rssi_out <= SAT_MAX);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done);

    p_abort_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |=> !win_done);

    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |-> $stable(rssi_out));
endmodule

bind rssi_win_acc rssi_win_acc_chk #(.OUT_W(OUT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_start (slot_start),
    .rssi_out   (rssi_out),
    .win_done   (win_done)
);

// File: tb/rssi_win_acc_tb.sv
module rssi_win_acc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] smp_i = '0, smp_q = '0;
    logic        smp_stb = 1'b0, slot_start = 1'b0;
    logic [10:0] cfg_start = '0, cfg_len = '0;
    logic [15:0] cfg_gain = '0;
    logic [15:0] rssi_out;
    logic        win_done;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rssi_win_acc dut_i (
        .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .smp_q(smp_q),
        .smp_stb(smp_stb), .slot_start(slot_start), .cfg_start(cfg_start),
        .cfg_len(cfg_len), .cfg_gain(cfg_gain), .rssi_out(rssi_out),
        .win_done(win_done)
    );

    function automatic longint isqrt(longint v);
        longint r = 0;
        for (int b = 16; b >= 0; b--) begin
            longint t = r + (longint'(1) << b);
            if (t * t <= v) r = t;
        end
        return r;
    endfunction

    function automatic longint contrib(int i, int q, int g);
        longint m  = isqrt(longint'(i) * i + longint'(q) * q);
        longint m1 = (m * 26981 + 32768) >>> 16;
        return (m1 * g + 32768) >>> 16;
    endfunction

    function automatic longint sat(longint v);
        return (v > 32767) ? 32767 : v;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic new_slot(int st, int ln, int g);
        @(negedge clk);
        cfg_start = 11'(st); cfg_len = 11'(ln); cfg_gain = 16'(g);
        slot_start = 1'b1;
        @(negedge clk);
        slot_start = 1'b0;
    endtask

    // Drives one strobe; returns at the falling edge after edge 0.
    task automatic strobe(int i, int q);
        @(negedge clk);
        smp_i = 16'(i); smp_q = 16'(q); smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic sample(int i, int q);
        strobe(i, q);
        repeat (22) @(negedge clk);
    endtask

    task automatic t_reset;
        check(rssi_out == 0, "R1 rssi_out", rssi_out, 0);
        check(win_done == 0, "R1 win_done", win_done, 0);
    endtask

    task automatic t_window;
        longint e = contrib(3000, 4000, 40000) + contrib(-1200, 700, 40000)
                  + contrib(20000, -15000, 40000);
        new_slot(2, 4, 40000);
        sample(30000, 30000);
        sample(-30000, 29000);
        sample(3000, 4000);
        sample(-1200, 700);
        check(rssi_out == 0, "R10 held before close", rssi_out, 0);
        strobe(20000, -15000);
        repeat (18) @(negedge clk);
        check(win_done == 0, "R5 done at edge 18", win_done, 0);
        check(rssi_out == 0, "R5 out at edge 18", rssi_out, 0);
        @(negedge clk);
        check(win_done == 1, "R5 done at edge 19", win_done, 1);
        check(rssi_out == 16'(e), "R2 R3 window sum", rssi_out, e);
        @(negedge clk);
        check(win_done == 0, "R5 single-cycle done", win_done, 0);
        sample(25000, 25000);
        check(rssi_out == 16'(e), "R3 after-close sample ignored", rssi_out, e);
    endtask

    task automatic t_empty;
        new_slot(1, 1, 50000);
        sample(10000, 10000);
        check(win_done == 0, "R6 no done at index 0", win_done, 0);
        strobe(10000, 10000);
        check(win_done == 0, "R6 done not yet at edge 0", win_done, 0);
        @(negedge clk);
        check(win_done == 1, "R6 done at edge 1", win_done, 1);
        check(rssi_out == 0, "R6 empty publishes 0", rssi_out, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_saturate;
        longint e = sat(contrib(30000, 30000, 65535) + contrib(-30000, 30000, 65535)
                      + contrib(30000, -30000, 65535));
        new_slot(0, 4, 65535);
        sample(30000, 30000);
        sample(-30000, 30000);
        sample(30000, -30000);
        check(rssi_out == 16'(e), "R4 saturated total", rssi_out, e);
    endtask

    task automatic t_abort;
        longint e = contrib(5000, -6000, 30000) + contrib(-7000, 2000, 30000);
        bit seen = 1'b0;
        new_slot(0, 3, 30000);
        sample(30000, 30000);
        strobe(30000, 30000);
        repeat (8) @(negedge clk);
        slot_start = 1'b1;
        @(negedge clk);
        slot_start = 1'b0;
        for (int k = 0; k < 25; k++) begin
            if (win_done) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, "R7 abort publishes nothing", seen, 0);
        check(rssi_out == 16'd32767, "R7 output held over abort", rssi_out, 32767);
        @(negedge clk);
        slot_start = 1'b1; smp_stb = 1'b1; smp_i = 16'(30000); smp_q = 16'(30000);
        @(negedge clk);
        slot_start = 1'b0; smp_stb = 1'b0;
        repeat (4) @(negedge clk);
        sample(5000, -6000);
        sample(-7000, 2000);
        check(rssi_out == 16'(e), "R7 cleared total and index", rssi_out, e);
    endtask

    task automatic t_gain_zero;
        new_slot(0, 3, 0);
        sample(30000, 30000);
        sample(-20000, 10000);
        check(rssi_out == 0, "R9 zero gain", rssi_out, 0);
    endtask

    task automatic t_busy;
        longint e = contrib(8000, 8000, 60000) + contrib(-9000, 1000, 60000);
        new_slot(0, 3, 60000);
        strobe(8000, 8000);
        repeat (5) @(negedge clk);
        strobe(30000, 30000);
        repeat (22) @(negedge clk);
        check(win_done == 0 && rssi_out == 0, "R8 busy strobe not counted", rssi_out, 0);
        sample(-9000, 1000);
        check(rssi_out == 16'(e), "R8 busy strobe ignored", rssi_out, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window();
        t_empty();
        t_saturate();
        t_abort();
        t_gain_zero();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule